// File: doc/BRIEF.md
# Clocked Single-Port Word Memory with Burst Address Counter

This block is one clocked access port into a 16-bit-wide on-chip word array. Every control, address and data input is registered on the rising clock edge. The access address of each cycle comes from one of two places. It is either the external address bus or an internal burst counter. That counter can be loaded, held, stepped by one or cleared to zero. A controller can therefore stream a run of consecutive words after it presents one starting address.

The controls are as follows:

- Two chip selects of opposite polarity must agree before any access takes place.
- Two active-low byte lanes pick which halves of the word are written or returned.
- An unclocked output enable masks the read bus.

A parameter selects the read path. The flow-through variant returns data right after the edge that registers the read. The pipelined variant adds one output register. In the pipelined variant, the output stays quiet until the port has been selected on two edges in a row.

Top module: `burst_sram_port`

## Requirements
- R1: With `strobe_n` low (and `cnt_clr_n` high), the access at that edge goes to `addr`, and the counter takes that value.
- R2: With `strobe_n` high, `cnt_en_n` low and `cnt_clr_n` high, the counter steps by one before the access, and the access uses the stepped value. The counter wraps from the top address to 0.
- R3: With `strobe_n`, `cnt_en_n` and `cnt_clr_n` all high, the counter keeps its value, so repeated accesses hit the same word.
- R4: `cnt_clr_n` low forces the access address and the counter to 0 in that same cycle, whatever `strobe_n` and `cnt_en_n` are.
- R5: A write (`we_n` low) on a selected edge stores `wdata[7:0]` only if `lb_n` is low and `wdata[15:8]` only if `ub_n` is low.
- R6: On reads, `rvalid[1]` reports the upper byte and `rvalid[0]` the lower byte. Each byte is valid only if its enable was low on the read edge. A byte that is not valid reads as 0 on `rdata`.
- R7: With PIPELINED=0, the data of a selected read appears on `rdata`/`rvalid` right after the edge that samples the read.
- R8: With PIPELINED=1, read data appears one clock later than in R7.
- R9: The port is selected only when `sel_n` is low and `sel` is high. On a deselected edge nothing is written, no read is produced, and the counter still follows R1 to R4.
- R10: With PIPELINED=1, the output for a read sampled on edge k is driven only if the port is also selected on edge k+1.
- R11: `oe_n` high forces `rvalid` to 0 and `rdata` to 0 at once, without waiting for a clock edge.
- R12: Reset clears the counter to 0 and the read outputs to invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; every input is sampled on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| addr | input | ADDR_W | External word address |
| wdata | input | 16 | Write data |
| strobe_n | input | 1 | Low: access `addr` and load it into the counter |
| cnt_en_n | input | 1 | Low (with strobe high): step the counter |
| cnt_clr_n | input | 1 | Low: clear the counter and access word 0 |
| we_n | input | 1 | Low: write, high: read |
| ub_n | input | 1 | Upper byte lane enable, active low |
| lb_n | input | 1 | Lower byte lane enable, active low |
| sel_n | input | 1 | Chip select, active low |
| sel | input | 1 | Chip select, active high |
| oe_n | input | 1 | Unclocked output enable, active low |
| rdata | output | 16 | Read data; lanes that are not valid read 0 |
| rvalid | output | 2 | Per-lane read valid: bit 1 upper, bit 0 lower |

## Verification
A wrong counter value appears as wrong read data. It shows on the first read from the counter after the fault, one edge later in flow-through and two edges later in pipelined. A lost or misdirected write stays hidden until that word is read back. The bench therefore reads every written address, and it also reads the neighbours that a misdirected burst write would have hit. A fault in the select tracking of the pipelined stage shows one cycle after a deselect, as a lane that is driven when it should be quiet.

// File: rtl/burst_sram_port.sv
module burst_sram_port #(
  parameter int ADDR_W    = 6,
  parameter bit PIPELINED = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [15:0]       wdata,
  input  logic              strobe_n,
  input  logic              cnt_en_n,
  input  logic              cnt_clr_n,
  input  logic              we_n,
  input  logic              ub_n,
  input  logic              lb_n,
  input  logic              sel_n,
  input  logic              sel,
  input  logic              oe_n,
  output logic [15:0]       rdata,
  output logic [1:0]        rvalid
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [15:0]       mem [DEPTH];
  logic [ADDR_W-1:0] cnt, acc, rd_addr;
  logic [1:0]        rd_be, out_be;
  logic              picked, rd_act;
  logic [15:0]       word, out_word;

  assign picked = !sel_n && sel;
  assign acc = !cnt_clr_n ? '0 :
               !strobe_n  ? addr :
               cnt + {{(ADDR_W-1){1'b0}}, !cnt_en_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) cnt <= '0;
    else        cnt <= acc;

  always_ff @(posedge clk)
    if (picked && !we_n) begin
      if (!lb_n) mem[acc][7:0]  <= wdata[7:0];
      if (!ub_n) mem[acc][15:8] <= wdata[15:8];
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      rd_act  <= 1'b0;
      rd_be   <= 2'b00;
      rd_addr <= '0;
    end else begin
      rd_act  <= picked && we_n;
      rd_be   <= {!ub_n, !lb_n};
      rd_addr <= acc;
    end

  assign word = mem[rd_addr];

  generate
    if (PIPELINED) begin : g_pipe
      logic [15:0] p_word;
      logic [1:0]  p_be;
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) p_be <= 2'b00;
        else        p_be <= (rd_act && picked) ? rd_be : 2'b00;
      always_ff @(posedge clk)
        p_word <= word;
      assign out_word = p_word;
      assign out_be   = p_be;
    end else begin : g_flow
      assign out_word = word;
      assign out_be   = rd_act ? rd_be : 2'b00;
    end
  endgenerate

  assign rvalid = oe_n ? 2'b00 : out_be;
  assign rdata  = {out_word[15:8] & {8{rvalid[1]}}, out_word[7:0] & {8{rvalid[0]}}};
endmodule

module burst_sram_port_chk #(
  parameter int ADDR_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              strobe_n,
  input logic              cnt_en_n,
  input logic              cnt_clr_n,
  input logic              sel_n,
  input logic              sel,
  input logic              oe_n,
  input logic [15:0]       rdata,
  input logic [1:0]        rvalid,
  input logic [ADDR_W-1:0] cnt
);
  assert_load_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && cnt_clr_n) |=> (cnt == $past(addr)));

  assert_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && !cnt_en_n && cnt_clr_n) |=> (cnt == $past(cnt) + {{(ADDR_W-1){1'b0}}, 1'b1}));

  assert_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (strobe_n && cnt_en_n && cnt_clr_n) |=> $stable(cnt));

  assert_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_clr_n |=> (cnt == '0));

  assert_lane_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (rvalid[1] || rdata[15:8] == 8'h00) && (rvalid[0] || rdata[7:0] == 8'h00));

  assert_deselect_quiet_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(!sel_n && sel) |=> (rvalid == 2'b00));

  assert_oe_mask_R11: assert property (@(posedge clk) disable iff (!rst_n)
    oe_n |-> (rvalid == 2'b00 && rdata == 16'h0000));
endmodule

bind burst_sram_port burst_sram_port_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .addr(addr), .strobe_n(strobe_n),
  .cnt_en_n(cnt_en_n), .cnt_clr_n(cnt_clr_n), .sel_n(sel_n), .sel(sel),
  .oe_n(oe_n), .rdata(rdata), .rvalid(rvalid), .cnt(cnt)
);

// File: tb/burst_sram_port_tb.sv
module burst_sram_port_tb_top;
  localparam int AW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [15:0] wdata = '0;
  logic strobe_n = 1'b1, cnt_en_n = 1'b1, cnt_clr_n = 1'b1, we_n = 1'b1;
  logic ub_n = 1'b1, lb_n = 1'b1, sel_n = 1'b1, sel = 1'b0, oe_n = 1'b0;
  logic [15:0] rdata_p, rdata_f;
  logic [1:0]  rvalid_p, rvalid_f;

  always #2 clk = ~clk;

  burst_sram_port #(.ADDR_W(AW), .PIPELINED(1'b1)) dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .strobe_n(strobe_n),
    .cnt_en_n(cnt_en_n), .cnt_clr_n(cnt_clr_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n),
    .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .rdata(rdata_p), .rvalid(rvalid_p));

  burst_sram_port #(.ADDR_W(AW), .PIPELINED(1'b0)) dut_ft_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wdata(wdata), .strobe_n(strobe_n),
    .cnt_en_n(cnt_en_n), .cnt_clr_n(cnt_clr_n), .we_n(we_n), .ub_n(ub_n), .lb_n(lb_n),
    .sel_n(sel_n), .sel(sel), .oe_n(oe_n), .rdata(rdata_f), .rvalid(rvalid_f));

  typedef struct {
    int          due;
    bit          pipe;
    logic [1:0]  v;
    logic [15:0] d;
    string       req;
  } item_t;

  item_t       q[$];
  int          checks = 0, errors = 0, edges = 0;
  logic [15:0] m_mem [1<<AW];
  logic [AW-1:0] m_cnt = '0;
  logic [1:0]  pend_v = 2'b00;
  logic [15:0] pend_d = '0;
  string       pend_req = "R12";
  bit          done = 1'b0;

  always @(posedge clk) edges <= edges + 1;

  task automatic check(input string req, input logic [17:0] act, input logic [17:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual v=%b d=%h expected v=%b d=%h", req, act[17:16], act[15:0], exp[17:16], exp[15:0]);
    end
  endtask

  always @(negedge clk) begin
    while (q.size() > 0 && q[0].due <= edges) begin
      item_t it;
      logic [1:0] v;
      logic [15:0] d;
      it = q.pop_front();
      v = oe_n ? 2'b00 : it.v;
      d = {it.d[15:8] & {8{v[1]}}, it.d[7:0] & {8{v[0]}}};
      if (it.pipe) check({it.req, "/R8"}, {rvalid_p, rdata_p}, {v, d});
      else         check({it.req, "/R7"}, {rvalid_f, rdata_f}, {v, d});
    end
  end

  task automatic cyc(input bit s_n, input bit ce_n, input bit clr_n, input bit w_n,
                     input bit u_n, input bit l_n, input bit cs_n, input bit cs, input bit oe,
                     input logic [AW-1:0] a, input logic [15:0] d, input string req);
    logic [AW-1:0] eff;
    logic [1:0] rv;
    logic [15:0] rd;
    bit pick;
    @(negedge clk);
    #1;
    strobe_n = s_n; cnt_en_n = ce_n; cnt_clr_n = clr_n; we_n = w_n;
    ub_n = u_n; lb_n = l_n; sel_n = cs_n; sel = cs; oe_n = oe; addr = a; wdata = d;
    pick = !cs_n && cs;
    eff = !clr_n ? '0 : !s_n ? a : (!ce_n ? m_cnt + 1'b1 : m_cnt);
    m_cnt = eff;
    if (pick && !w_n) begin
      if (!l_n) m_mem[eff][7:0]  = d[7:0];
      if (!u_n) m_mem[eff][15:8] = d[15:8];
    end
    rv = (pick && w_n) ? {!u_n, !l_n} : 2'b00;
    rd = {m_mem[eff][15:8] & {8{rv[1]}}, m_mem[eff][7:0] & {8{rv[0]}}};
    q.push_back('{edges + 1, 1'b0, rv, rd, req});
    q.push_back('{edges + 1, 1'b1, pick ? pend_v : 2'b00, pend_d, pend_req});
    pend_v = rv; pend_d = rd; pend_req = req;
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [15:0] d, input bit u_n, input bit l_n, input string req);
    cyc(0, 1, 1, 0, u_n, l_n, 0, 1, 0, a, d, req);
  endtask
  task automatic rd_at(input logic [AW-1:0] a, input bit u_n, input bit l_n, input string req);
    cyc(0, 1, 1, 1, u_n, l_n, 0, 1, 0, a, 16'h0, req);
  endtask
  task automatic idle(input string req);
    cyc(1, 1, 1, 1, 0, 0, 1, 0, 0, '0, 16'h0, req);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check("R12 reset pipe", {rvalid_p, rdata_p}, 18'h0);
    check("R12 reset flow", {rvalid_f, rdata_f}, 18'h0);
    // counter is 0 after reset: hold-mode write lands at word 0
    cyc(1, 1, 1, 0, 0, 0, 0, 1, 0, 6'd33, 16'h0F0F, "R12");
    rd_at(6'd0, 0, 0, "R12");
    // external loads and burst writes
    wr(6'd5, 16'hA5A5, 0, 0, "R1");
    wr(6'd10, 16'h1111, 0, 0, "R1");
    cyc(1, 0, 1, 0, 0, 0, 0, 1, 0, 6'd0, 16'h2222, "R2");
    cyc(1, 0, 1, 0, 0, 0, 0, 1, 0, 6'd0, 16'h3333, "R2");
    cyc(1, 1, 1, 0, 0, 0, 0, 1, 0, 6'd0, 16'h4444, "R3");
    cyc(1, 1, 1, 0, 0, 0, 0, 1, 0, 6'd0, 16'h5555, "R3");
    rd_at(6'd10, 0, 0, "R1");
    cyc(1, 0, 1, 1, 0, 0, 0, 1, 0, 6'd0, 16'h0, "R2");
    cyc(1, 0, 1, 1, 0, 0, 0, 1, 0, 6'd0, 16'h0, "R3");
    cyc(1, 1, 1, 1, 0, 0, 0, 1, 0, 6'd0, 16'h0, "R3");
    rd_at(6'd13, 0, 0, "R3");
    // byte lanes
    wr(6'd20, 16'hFFFF, 0, 0, "R5");
    wr(6'd20, 16'h1234, 1, 0, "R5");
    wr(6'd20, 16'hAB00, 0, 1, "R5");
    rd_at(6'd20, 0, 0, "R5");
    rd_at(6'd20, 1, 0, "R6");
    rd_at(6'd20, 0, 1, "R6");
    rd_at(6'd20, 1, 1, "R6");
    // clear has priority over strobe
    wr(6'd30, 16'h3030, 0, 0, "R4");
    cyc(0, 1, 0, 0, 0, 0, 0, 1, 0, 6'd30, 16'h0C0C, "R4");
    rd_at(6'd30, 0, 0, "R4");
    cyc(1, 0, 0, 1, 0, 0, 0, 1, 0, 6'd30, 16'h0, "R4");
    // wrap from top to 0
    wr(6'd63, 16'h6363, 0, 0, "R2");
    cyc(1, 0, 1, 0, 0, 0, 0, 1, 0, 6'd0, 16'h0001, "R2");
    rd_at(6'd0, 0, 0, "R2");
    rd_at(6'd63, 0, 0, "R2");
    // deselect
    cyc(0, 1, 1, 0, 0, 0, 1, 1, 0, 6'd5, 16'hDEAD, "R9");
    cyc(0, 1, 1, 0, 0, 0, 0, 0, 0, 6'd5, 16'hBEEF, "R9");
    cyc(0, 1, 1, 1, 0, 0, 1, 0, 0, 6'd5, 16'h0, "R9");
    rd_at(6'd5, 0, 0, "R9");
    cyc(0, 1, 1, 1, 0, 0, 1, 1, 0, 6'd10, 16'h0, "R9");
    cyc(1, 0, 1, 1, 0, 0, 0, 1, 0, 6'd0, 16'h0, "R9");
    // pipelined reactivation
    idle("R10");
    rd_at(6'd5, 0, 0, "R10");
    idle("R10");
    rd_at(6'd5, 0, 0, "R10");
    rd_at(6'd10, 0, 0, "R10");
    rd_at(6'd20, 0, 0, "R10");
    // output enable
    cyc(0, 1, 1, 1, 0, 0, 0, 1, 1, 6'd5, 16'h0, "R11");
    cyc(0, 1, 1, 1, 0, 0, 0, 1, 1, 6'd10, 16'h0, "R11");
    cyc(0, 1, 1, 1, 0, 0, 0, 1, 0, 6'd20, 16'h0, "R11");
    cyc(0, 1, 1, 1, 0, 0, 0, 1, 0, 6'd5, 16'h0, "R11");
    idle("R9");
    idle("R9");
    idle("R9");
    @(negedge clk);
    @(negedge clk);
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule